// File: doc/BRIEF.md
# Rotate, Shift and Single-Bit Unit

This block performs the rotate, shift and single-bit operations of an 8-bit datapath. Each cycle it takes an operation code, an operand byte, a bit index and the current carry value. It produces the result byte and a write-enable on the same cycle, without any register in that path.

The block keeps its own carry and zero flags in registers. They load on the next rising clock edge, and only for operations that define them. The surrounding datapath writes the result back when the write-enable is high. It feeds the carry value it keeps for the machine into the carry input.

There are two rotate families. One is circular and the other rotates through the carry. Each family has an accumulator form and a general-register form. There is also a shift-left, a bit test that touches only the zero flag, and bit set and bit clear.

Top module: `rotbit_unit`

## Requirements
- R1: Operation code 1 (accumulator circular left) and code 5 (register circular left) give the result `{opnd[6:0], opnd[7]}`, raise the write-enable, and load the carry flag with opnd[7] at the next clock edge.
- R2: Operation code 2 (accumulator circular right) and code 6 (register circular right) give `{opnd[0], opnd[7:1]}`, raise the write-enable, and load the carry flag with opnd[0].
- R3: Operation code 3 (accumulator left through carry) and code 7 (register left through carry) give `{opnd[6:0], carry_in}`, raise the write-enable, and load the carry flag with opnd[7].
- R4: Operation code 4 (accumulator right through carry) and code 8 (register right through carry) give `{carry_in, opnd[7:1]}`, raise the write-enable, and load the carry flag with opnd[0].
- R5: The accumulator forms (codes 1 to 4) leave the zero flag unchanged.
- R6: The register forms (codes 5 to 8) and the shift-left (code 9) load the zero flag with 1 when the result byte is 0, and with 0 otherwise.
- R7: Operation code 9 (shift left) gives `{opnd[6:0], 1'b0}`, raises the write-enable, and loads the carry flag with opnd[7].
- R8: Operation code 10 (bit test) loads the zero flag with the inverse of opnd[bit_idx]. It keeps the write-enable low and leaves the carry flag unchanged.
- R9: Operation code 11 (set) forces opnd[bit_idx] to 1 and code 12 (clear) forces it to 0. Every other bit passes through unchanged. Both raise the write-enable and leave both flags unchanged.
- R10: Operation codes 0, 13, 14 and 15 keep the write-enable low and leave both flags unchanged.
- R11: While rst_n is low, both flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags load on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| op_i | input | 4 | Operation code |
| opnd_i | input | 8 | Operand byte |
| bit_i | input | 3 | Bit index for test, set and clear |
| cin_i | input | 1 | Current carry value, used by the through-carry rotates |
| res_o | output | 8 | Result byte (combinational) |
| we_o | output | 1 | Result write-enable (combinational) |
| flag_c_o | output | 1 | Registered carry flag |
| flag_z_o | output | 1 | Registered zero flag |

## Verification
The bench crosses all 16 operation codes with all 256 operand bytes, both carry-input values and all eight bit indices.

The operand patterns with only bit 7 set, and those with only bit 0 set, separate the circular rotates from the through-carry rotates, because the carry input and the wrapped bit then disagree. The bytes 0x00, 0x80 and 0x01 separate a zero flag that follows the result from one that is held: shifting 0x80 left gives a zero result with the carry set.

The index sweep on test, set and clear exposes any wrong bit selection or any spill into a neighbouring bit. The bench keeps its own model of the flags across the whole sweep. That model catches any update of a flag that should have held.

// File: rtl/rb_pkg.sv
package rb_pkg;
    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_ARLC = 4'd1,
        OP_ARRC = 4'd2,
        OP_ARL  = 4'd3,
        OP_ARR  = 4'd4,
        OP_RLC  = 4'd5,
        OP_RRC  = 4'd6,
        OP_RL   = 4'd7,
        OP_RR   = 4'd8,
        OP_SLA  = 4'd9,
        OP_BIT  = 4'd10,
        OP_SET  = 4'd11,
        OP_RES  = 4'd12
    } rb_op_e;
endpackage

// File: rtl/rb_shift.sv
module rb_shift
    import rb_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  rb_op_e         op,
    input  logic [W-1:0]   val,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout,
    output logic           hit,
    output logic           acc_form
);
    always_comb begin
        hit      = 1'b1;
        acc_form = 1'b0;
        res      = val;
        cout     = cin;
        unique case (op)
            OP_ARLC, OP_RLC: begin
                res  = {val[W-2:0], val[W-1]};
                cout = val[W-1];
            end
            OP_ARRC, OP_RRC: begin
                res  = {val[0], val[W-1:1]};
                cout = val[0];
            end
            OP_ARL, OP_RL: begin
                res  = {val[W-2:0], cin};
                cout = val[W-1];
            end
            OP_ARR, OP_RR: begin
                res  = {cin, val[W-1:1]};
                cout = val[0];
            end
            OP_SLA: begin
                res  = {val[W-2:0], 1'b0};
                cout = val[W-1];
            end
            default: hit = 1'b0;
        endcase
        if (op == OP_ARLC || op == OP_ARRC || op == OP_ARL || op == OP_ARR)
            acc_form = 1'b1;
    end
endmodule

// File: rtl/rb_bitop.sv
module rb_bitop
    import rb_pkg::*;
#(
    parameter int unsigned W  = 8,
    localparam int unsigned IW = $clog2(W)
) (
    input  rb_op_e         op,
    input  logic [W-1:0]   val,
    input  logic [IW-1:0]  idx,
    output logic [W-1:0]   res,
    output logic           tst_z,
    output logic           is_test,
    output logic           is_write
);
    logic [W-1:0] mask;

    assign mask  = {{(W-1){1'b0}}, 1'b1} << idx;
    assign tst_z = ~|(val & mask);

    always_comb begin
        res      = val;
        is_test  = 1'b0;
        is_write = 1'b0;
        unique case (op)
            OP_BIT: is_test = 1'b1;
            OP_SET: begin
                res      = val | mask;
                is_write = 1'b1;
            end
            OP_RES: begin
                res      = val & ~mask;
                is_write = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rb_flags.sv
module rb_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_c,
    input  logic ld_z,
    input  logic c_d,
    input  logic z_d,
    output logic c_q,
    output logic z_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= 1'b0;
            z_q <= 1'b0;
        end else begin
            if (ld_c) c_q <= c_d;
            if (ld_z) z_q <= z_d;
        end
    end
endmodule

// File: rtl/rotbit_unit.sv
module rotbit_unit
    import rb_pkg::*;
#(
    parameter int unsigned W  = 8,
    localparam int unsigned IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_i,
    input  logic [W-1:0]  opnd_i,
    input  logic [IW-1:0] bit_i,
    input  logic          cin_i,
    output logic [W-1:0]  res_o,
    output logic          we_o,
    output logic          flag_c_o,
    output logic          flag_z_o
);
    rb_op_e       op_e;
    logic [W-1:0] sh_res, bo_res;
    logic         sh_cout, sh_hit, sh_acc;
    logic         bo_z, bo_test, bo_write;
    logic         ld_c, ld_z, c_d, z_d;

    assign op_e = rb_op_e'(op_i);

    rb_shift #(.W(W)) u_shift (
        .op(op_e), .val(opnd_i), .cin(cin_i),
        .res(sh_res), .cout(sh_cout), .hit(sh_hit), .acc_form(sh_acc)
    );

    rb_bitop #(.W(W)) u_bitop (
        .op(op_e), .val(opnd_i), .idx(bit_i),
        .res(bo_res), .tst_z(bo_z), .is_test(bo_test), .is_write(bo_write)
    );

    always_comb begin
        res_o = sh_hit ? sh_res : bo_res;
        we_o  = sh_hit | bo_write;
        ld_c  = sh_hit;
        c_d   = sh_cout;
        ld_z  = (sh_hit & ~sh_acc) | bo_test;
        z_d   = sh_hit ? ~|sh_res : bo_z;
    end

    rb_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .ld_c(ld_c), .ld_z(ld_z), .c_d(c_d), .z_d(z_d),
        .c_q(flag_c_o), .z_q(flag_z_o)
    );
endmodule

// File: rtl/rotbit_chk.sv
module rotbit_chk #(
    parameter int unsigned W  = 8,
    localparam int unsigned IW = $clog2(W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_i,
    input logic [W-1:0]  opnd_i,
    input logic [IW-1:0] bit_i,
    input logic          cin_i,
    input logic [W-1:0]  res_o,
    input logic          we_o,
    input logic          flag_c_o,
    input logic          flag_z_o
);
    AST_CIRC_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd1 || op_i == 4'd5) |-> (we_o && res_o == {opnd_i[W-2:0], opnd_i[W-1]})); // R1
    AST_CARRY_RIGHT_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd4 || op_i == 4'd8) |=> (flag_c_o == $past(opnd_i[0]))); // R4
    AST_ACC_ZERO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd1 && op_i <= 4'd4) |=> $stable(flag_z_o)); // R5
    AST_TEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd10) |=> (flag_z_o == ~$past(opnd_i[bit_i]) && $stable(flag_c_o))); // R8
    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd10) |-> !we_o); // R8
    AST_SETCLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd11 || op_i == 4'd12) |=> ($stable(flag_c_o) && $stable(flag_z_o))); // R9
    AST_INVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 || op_i >= 4'd13) |-> !we_o); // R10
    AST_INVALID_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 || op_i >= 4'd13) |=> ($stable(flag_c_o) && $stable(flag_z_o))); // R10
    always_comb if (!rst_n) AST_RESET_FLAGS: assert (!flag_c_o && !flag_z_o); // R11
endmodule

bind rotbit_unit rotbit_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .opnd_i(opnd_i), .bit_i(bit_i),
    .cin_i(cin_i), .res_o(res_o), .we_o(we_o), .flag_c_o(flag_c_o), .flag_z_o(flag_z_o)
);

// File: tb/sim_rotbit_unit.sv
module sim_rotbit_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] opnd_i = 8'd0;
    logic [2:0] bit_i = 3'd0;
    logic       cin_i = 1'b0;
    logic [7:0] res_o;
    logic       we_o, flag_c_o, flag_z_o;

    int checks = 0;
    int fails  = 0;
    int mc = 0, mz = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rotbit_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opnd_i(opnd_i), .bit_i(bit_i),
        .cin_i(cin_i), .res_o(res_o), .we_o(we_o), .flag_c_o(flag_c_o), .flag_z_o(flag_z_o)
    );

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s op=%0d opnd=%0d bit=%0d cin=%0d act=%0d exp=%0d",
                     req, op_i, opnd_i, bit_i, cin_i, act, expv);
        end
    endtask

    task automatic run_one(input int op, input int v, input int c, input int b);
        int r, nc, we, ldc, ldz, nz, p, bv;
        string rq;
        p  = 2 ** b;
        bv = (v / p) % 2;
        r = 0; nc = mc; nz = mz; we = 0; ldc = 0; ldz = 0; rq = "R10";
        case (op)
            1, 5: begin r = (v * 2) % 256 + v / 128; nc = v / 128; rq = "R1"; end
            2, 6: begin r = v / 2 + (v % 2) * 128;   nc = v % 2;   rq = "R2"; end
            3, 7: begin r = (v * 2) % 256 + c;       nc = v / 128; rq = "R3"; end
            4, 8: begin r = v / 2 + c * 128;         nc = v % 2;   rq = "R4"; end
            9:    begin r = (v * 2) % 256;           nc = v / 128; rq = "R7"; end
            10:   begin nz = (bv == 0) ? 1 : 0; ldz = 1; rq = "R8"; end
            11:   begin r = v + (1 - bv) * p; we = 1; rq = "R9"; end
            12:   begin r = v - bv * p;       we = 1; rq = "R9"; end
            default: ;
        endcase
        if (op >= 1 && op <= 9) begin
            we = 1; ldc = 1;
            if (op >= 5) begin ldz = 1; nz = (r == 0) ? 1 : 0; end
        end
        @(negedge clk);
        op_i = 4'(op); opnd_i = 8'(v); cin_i = 1'(c); bit_i = 3'(b);
        #1;
        check({rq, " we"}, int'(we_o), we);
        if (we == 1) check({rq, " result"}, int'(res_o), r);
        if (ldc == 1) mc = nc;
        if (ldz == 1) mz = nz;
        @(posedge clk);
        #1;
        check({rq, (op >= 1 && op <= 4) ? "/R5" : (ldz == 1 && op != 10) ? "/R6" : "", " carry"},
              int'(flag_c_o), mc);
        check({rq, (op >= 1 && op <= 4) ? "/R5" : (ldz == 1 && op != 10) ? "/R6" : "", " zero"},
              int'(flag_z_o), mz);
    endtask

    initial begin
        #23;
        check("R11 reset carry", int'(flag_c_o), 0);
        check("R11 reset zero", int'(flag_z_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int op = 0; op < 16; op++)
            for (int v = 0; v < 256; v++)
                for (int c = 0; c < 2; c++)
                    for (int b = 0; b < 8; b++)
                        if (!done) run_one(op, v, c, b);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule